// File: doc/BRIEF.md
# Exception Entry and Data-Fault Status Unit

This block sits between the fault-detecting logic of a processor core and its fetch stage. Fault sources post requests into a pending mask. When the core reaches a point where an exception may be taken, it raises a take strobe. The unit then picks the lowest-numbered pending source and clears that source's pending bit. It produces the handler address, which is the exception number shifted left by eight bits. It also fills the two save/restore values: the return address and the machine-state word at the time of entry.

On the same entry the unit produces the new machine-state word, with translation and user privilege turned off. It emits a one-cycle flush pulse for all cached address translations. When the taken exception is the data-fault number, it also writes a new fault-status word. That word is encoded from a cause vector supplied by the translation logic.

All results are registered. They appear on the clock edge that samples the take strobe, and the pulse outputs last one cycle.

Top module: `exc_entry`

## Requirements
- R1: While `rst_n` is low and after its release, `ent_vld_o`, `flush_o` and `fst_we_o` are 0, `vec_o` and `fst_o` are 0, and no source is pending.
- R2: A clock edge that samples `take_i`=1 while at least one source is pending produces, for the following cycle only, `ent_vld_o`=1. `ent_num_o` then holds the index of the lowest-numbered pending source. An edge without `take_i`, or with nothing pending, produces `ent_vld_o`=0.
- R3: On entry, `vec_o` equals `ent_num_o` shifted left by 8 bits, zero-extended to 32 bits.
- R4: On entry, `save_pc_o` is `pc_i - 4` (modulo 2^32) when `save_cur_i`=1, and `pc_i` when `save_cur_i`=0. Both values are sampled at the take edge.
- R5: On entry, `save_msr_o` equals the sampled `msr_i`. `msr_o` equals `msr_i` with bit 5 (instruction translation), bit 4 (data translation) and bit 14 (user privilege) cleared.
- R6: The pending bit of the taken source is cleared by the entry, and all other pending bits stay set. A bit of `raise_i` that is high at an edge sets that source's pending bit.
- R7: `fst_we_o` pulses only on entries with exception number 3. On those entries `fst_o` is loaded from `cause_i`, whose bits are: [0] no-translation, [1] protection, [2] unsupported, [3] direct-store, [4] store, [5] breakpoint match, [6] external control. The first of [0], [1], [2] that is set contributes 0x40000000, 0x08000000 or 0x80000000 respectively, and only that one contributes. On other entries `fst_o` keeps its value.
- R8: In the status word, a direct-store cause adds 0x04000000 only when the unsupported cause is the recorded primary cause. Store adds 0x02000000, breakpoint match adds 0x00400000 and external control adds 0x00100000, independently of the other bits.
- R9: `flush_o` pulses in exactly the cycles in which `ent_vld_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | 16 | Per-source request bits, one per exception number, ORed into the pending mask |
| take_i | input | 1 | Core is at a point where an exception may be entered |
| cause_i | input | 7 | Data-fault cause flags (see R7) |
| pc_i | input | 32 | Address of the instruction after the faulting one |
| save_cur_i | input | 1 | 1: save the faulting instruction address (pc_i - 4); 0: save pc_i |
| msr_i | input | 32 | Current machine-state word |
| ent_vld_o | output | 1 | One-cycle pulse: an exception was entered |
| ent_num_o | output | 4 | Number of the entered exception |
| vec_o | output | 32 | Handler address to load into the program counter |
| save_pc_o | output | 32 | Saved return address |
| save_msr_o | output | 32 | Saved machine-state word |
| msr_o | output | 32 | Machine-state word to use inside the handler |
| fst_we_o | output | 1 | One-cycle pulse: fault-status word updated |
| fst_o | output | 32 | Data-fault status word |
| flush_o | output | 1 | One-cycle pulse: flush all cached translations |

## Verification
The status encoding is tried with cause vectors that set two or three primary causes at once. These show whether the priority picks exactly one primary cause. A direct-store flag is applied both with and without the unsupported cause, which shows whether the modifier is gated by the recorded primary. Non-data-fault entries placed between data-fault entries show whether the status word is held. Several sources are raised in the same cycle to check the lowest-first order and the clearing of only the taken bit. Takes with nothing pending must produce no entry. The return-address choice is exercised with both flag values and at address zero, where the subtraction wraps.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Cause flags, LSB first: notrans is cause_i[0]
    typedef struct packed {
        logic ext;
        logic brk;
        logic store;
        logic direct;
        logic unsup;
        logic prot;
        logic notrans;
    } exc_cause_t;

    localparam int unsigned CAUSE_W = $bits(exc_cause_t);

    localparam logic [31:0] FST_NOTRANS = 32'h4000_0000;
    localparam logic [31:0] FST_PROT    = 32'h0800_0000;
    localparam logic [31:0] FST_UNSUP   = 32'h8000_0000;
    localparam logic [31:0] FST_DIRECT  = 32'h0400_0000;
    localparam logic [31:0] FST_STORE   = 32'h0200_0000;
    localparam logic [31:0] FST_BRK     = 32'h0040_0000;
    localparam logic [31:0] FST_EXT     = 32'h0010_0000;
    localparam logic [31:0] FST_PRIMARY = FST_NOTRANS | FST_PROT | FST_UNSUP;

endpackage

// File: rtl/exc_pick.sv
module exc_pick #(
    parameter int unsigned NSRC = 16,
    localparam int unsigned IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend_i,
    output logic            any_o,
    output logic [IW-1:0]   idx_o
);

    logic [NSRC:0]   seen;
    logic [NSRC-1:0] first;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        assign first[g]  = pend_i[g] & ~seen[g];
        assign seen[g+1] = seen[g] | pend_i[g];
    end

    assign any_o = seen[NSRC];

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (first[i]) begin
                idx_o = idx_o | IW'(i);
            end
        end
    end

endmodule

// File: rtl/exc_fst_enc.sv
module exc_fst_enc
    import exc_pkg::*;
(
    input  exc_cause_t  cause_i,
    output logic [31:0] fst_o
);

    logic [31:0] primary;
    logic [31:0] extra;

    always_comb begin
        primary = '0;
        if (cause_i.notrans) begin
            primary = FST_NOTRANS;
        end else if (cause_i.prot) begin
            primary = FST_PROT;
        end else if (cause_i.unsup) begin
            primary = FST_UNSUP | (cause_i.direct ? FST_DIRECT : 32'h0);
        end
    end

    always_comb begin
        extra = '0;
        if (cause_i.store) extra = extra | FST_STORE;
        if (cause_i.brk)   extra = extra | FST_BRK;
        if (cause_i.ext)   extra = extra | FST_EXT;
    end

    assign fst_o = primary | extra;

endmodule

// File: rtl/exc_ctx.sv
module exc_ctx #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned INSN_BYTES = 4,
    parameter int unsigned IR_BIT     = 5,
    parameter int unsigned DR_BIT     = 4,
    parameter int unsigned PR_BIT     = 14
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            save_cur_i,
    input  logic [XLEN-1:0] msr_i,
    output logic [XLEN-1:0] save_pc_o,
    output logic [XLEN-1:0] msr_o
);

    logic [XLEN-1:0] keep;

    for (genvar g = 0; g < XLEN; g++) begin : g_mask
        if (g == IR_BIT || g == DR_BIT || g == PR_BIT) begin : g_drop
            assign keep[g] = 1'b0;
        end else begin : g_pass
            assign keep[g] = 1'b1;
        end
    end

    assign save_pc_o = save_cur_i ? (pc_i - XLEN'(INSN_BYTES)) : pc_i;
    assign msr_o     = msr_i & keep;

endmodule

// File: rtl/exc_entry.sv
module exc_entry
    import exc_pkg::*;
#(
    parameter int unsigned NSRC       = 16,
    parameter int unsigned XLEN       = 32,
    parameter int unsigned VEC_SHIFT  = 8,
    parameter int unsigned DFAULT_NUM = 3,
    parameter int unsigned INSN_BYTES = 4,
    parameter int unsigned IR_BIT     = 5,
    parameter int unsigned DR_BIT     = 4,
    parameter int unsigned PR_BIT     = 14,
    localparam int unsigned IW        = $clog2(NSRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     raise_i,
    input  logic                take_i,
    input  logic [CAUSE_W-1:0]  cause_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic                save_cur_i,
    input  logic [XLEN-1:0]     msr_i,
    output logic                ent_vld_o,
    output logic [IW-1:0]       ent_num_o,
    output logic [XLEN-1:0]     vec_o,
    output logic [XLEN-1:0]     save_pc_o,
    output logic [XLEN-1:0]     save_msr_o,
    output logic [XLEN-1:0]     msr_o,
    output logic                fst_we_o,
    output logic [31:0]         fst_o,
    output logic                flush_o
);

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            vld;
        logic [IW-1:0]   num;
        logic [XLEN-1:0] vec;
        logic [XLEN-1:0] spc;
        logic [XLEN-1:0] smsr;
        logic [XLEN-1:0] nmsr;
        logic            fwe;
        logic [31:0]     fst;
        logic            flush;
    } state_t;

    state_t st_d, st_q;

    logic            pick_any;
    logic [IW-1:0]   pick_idx;
    logic [31:0]     fst_enc;
    logic [XLEN-1:0] ctx_pc;
    logic [XLEN-1:0] ctx_msr;
    logic [NSRC-1:0] clr_d;

    exc_pick #(.NSRC(NSRC)) u_pick (
        .pend_i (st_q.pend),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    exc_fst_enc u_fst (
        .cause_i (exc_cause_t'(cause_i)),
        .fst_o   (fst_enc)
    );

    exc_ctx #(
        .XLEN       (XLEN),
        .INSN_BYTES (INSN_BYTES),
        .IR_BIT     (IR_BIT),
        .DR_BIT     (DR_BIT),
        .PR_BIT     (PR_BIT)
    ) u_ctx (
        .pc_i       (pc_i),
        .save_cur_i (save_cur_i),
        .msr_i      (msr_i),
        .save_pc_o  (ctx_pc),
        .msr_o      (ctx_msr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.fwe   = 1'b0;
        st_d.flush = 1'b0;
        clr_d      = '0;
        if (take_i && pick_any) begin
            st_d.vld     = 1'b1;
            st_d.flush   = 1'b1;
            st_d.num     = pick_idx;
            st_d.vec     = XLEN'(pick_idx) << VEC_SHIFT;
            st_d.spc     = ctx_pc;
            st_d.smsr    = msr_i;
            st_d.nmsr    = ctx_msr;
            clr_d[pick_idx] = 1'b1;
            if (pick_idx == IW'(DFAULT_NUM)) begin
                st_d.fwe = 1'b1;
                st_d.fst = fst_enc;
            end
        end
        st_d.pend = (st_q.pend & ~clr_d) | raise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_vld_o  = st_q.vld;
    assign ent_num_o  = st_q.num;
    assign vec_o      = st_q.vec;
    assign save_pc_o  = st_q.spc;
    assign save_msr_o = st_q.smsr;
    assign msr_o      = st_q.nmsr;
    assign fst_we_o   = st_q.fwe;
    assign fst_o      = st_q.fst;
    assign flush_o    = st_q.flush;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int unsigned NSRC       = 16,
    parameter int unsigned XLEN       = 32,
    parameter int unsigned VEC_SHIFT  = 8,
    parameter int unsigned DFAULT_NUM = 3,
    parameter int unsigned IR_BIT     = 5,
    parameter int unsigned DR_BIT     = 4,
    parameter int unsigned PR_BIT     = 14,
    localparam int unsigned IW        = $clog2(NSRC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take_i,
    input logic [XLEN-1:0] msr_i,
    input logic            ent_vld_o,
    input logic [IW-1:0]   ent_num_o,
    input logic [XLEN-1:0] vec_o,
    input logic [XLEN-1:0] save_msr_o,
    input logic [XLEN-1:0] msr_o,
    input logic            fst_we_o,
    input logic [31:0]     fst_o,
    input logic            flush_o
);

    // R2
    entry_needs_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld_o |-> $past(take_i));

    // R3
    vec_from_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld_o |-> (vec_o == (XLEN'(ent_num_o) << VEC_SHIFT)));

    // R5
    msr_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld_o |-> (save_msr_o == $past(msr_i)));

    // R5
    msr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld_o |-> (!msr_o[IR_BIT] && !msr_o[DR_BIT] && !msr_o[PR_BIT]));

    // R7
    fst_only_dfault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fst_we_o |-> (ent_vld_o && ent_num_o == IW'(DFAULT_NUM)));

    // R7
    one_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fst_we_o |-> ($countones(fst_o & 32'hC800_0000) <= 1));

    // R7
    fst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fst_we_o |-> $stable(fst_o));

    // R8
    direct_needs_unsup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fst_we_o && fst_o[26]) |-> fst_o[31]);

    // R9
    flush_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld_o |-> flush_o);

    // R9
    entry_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> ent_vld_o);

endmodule

bind exc_entry exc_entry_chk #(
    .NSRC       (NSRC),
    .XLEN       (XLEN),
    .VEC_SHIFT  (VEC_SHIFT),
    .DFAULT_NUM (DFAULT_NUM),
    .IR_BIT     (IR_BIT),
    .DR_BIT     (DR_BIT),
    .PR_BIT     (PR_BIT)
) u_exc_entry_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take_i),
    .msr_i      (msr_i),
    .ent_vld_o  (ent_vld_o),
    .ent_num_o  (ent_num_o),
    .vec_o      (vec_o),
    .save_msr_o (save_msr_o),
    .msr_o      (msr_o),
    .fst_we_o   (fst_we_o),
    .fst_o      (fst_o),
    .flush_o    (flush_o)
);

// File: tb/test_exc_entry.sv
`timescale 1ns/100ps
module test_exc_entry;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] raise_i = '0;
    logic        take_i = 1'b0;
    logic [6:0]  cause_i = '0;
    logic [31:0] pc_i = '0;
    logic        save_cur_i = 1'b0;
    logic [31:0] msr_i = '0;
    logic        ent_vld_o;
    logic [3:0]  ent_num_o;
    logic [31:0] vec_o, save_pc_o, save_msr_o, msr_o, fst_o;
    logic        fst_we_o, flush_o;

    exc_entry i_exc_entry (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .take_i(take_i),
        .cause_i(cause_i), .pc_i(pc_i), .save_cur_i(save_cur_i), .msr_i(msr_i),
        .ent_vld_o(ent_vld_o), .ent_num_o(ent_num_o), .vec_o(vec_o),
        .save_pc_o(save_pc_o), .save_msr_o(save_msr_o), .msr_o(msr_o),
        .fst_we_o(fst_we_o), .fst_o(fst_o), .flush_o(flush_o)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [3:0]  num;
        logic [31:0] vec, spc, smsr, nmsr, fst;
        logic        fwe;
    } exp_t;

    exp_t        sb[$];
    int          nvec = 0;
    int          nbad = 0;
    logic [31:0] last_fst = '0;
    bit          done = 1'b0;

    // Expected status word from R7 and R8
    function automatic logic [31:0] want_fst(input logic [6:0] c);
        logic [31:0] w;
        w = '0;
        if (c[0])      w = 32'h4000_0000;
        else if (c[1]) w = 32'h0800_0000;
        else if (c[2]) w = c[3] ? 32'h8400_0000 : 32'h8000_0000;
        if (c[4]) w = w | 32'h0200_0000;
        if (c[5]) w = w | 32'h0040_0000;
        if (c[6]) w = w | 32'h0010_0000;
        return w;
    endfunction

    task automatic post(input logic [15:0] mask);
        @(negedge clk);
        raise_i = mask;
        @(negedge clk);
        raise_i = '0;
    endtask

    task automatic take(input logic [3:0] num, input logic [6:0] c,
                        input logic [31:0] pc, input logic [31:0] msr,
                        input logic cur);
        exp_t e;
        e.num  = num;
        e.vec  = {20'h0, num, 8'h00};
        e.spc  = cur ? pc - 32'd4 : pc;
        e.smsr = msr;
        e.nmsr = msr & ~32'h0000_4030;
        e.fwe  = (num == 4'd3);
        if (e.fwe) last_fst = want_fst(c);
        e.fst  = last_fst;
        @(negedge clk);
        sb.push_back(e);
        take_i = 1'b1; cause_i = c; pc_i = pc; msr_i = msr; save_cur_i = cur;
        @(negedge clk);
        take_i = 1'b0;
    endtask

    task automatic take_idle(input string tag);
        @(negedge clk);
        take_i = 1'b1;
        @(negedge clk);
        take_i = 1'b0;
        nvec++;
        if (ent_vld_o !== 1'b0 || flush_o !== 1'b0) begin
            nbad++;
            $display("FAIL %s: entry with nothing pending vld=%b flush=%b expected 0 0",
                     tag, ent_vld_o, flush_o);
        end
    endtask

    // Monitor: compare each entry against the scoreboard (R2 R3 R4 R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (rst_n && ent_vld_o) begin
            nvec++;
            if (sb.size() == 0) begin
                nbad++;
                $display("FAIL R2: unexpected entry num=%0d expected none", ent_num_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (ent_num_o !== e.num || vec_o !== e.vec || save_pc_o !== e.spc ||
                    save_msr_o !== e.smsr || msr_o !== e.nmsr || fst_we_o !== e.fwe ||
                    fst_o !== e.fst || flush_o !== 1'b1) begin
                    nbad++;
                    $display("FAIL R2/R3/R4/R5/R7/R8/R9: num=%0d vec=%h spc=%h smsr=%h nmsr=%h fwe=%b fst=%h flush=%b expected num=%0d vec=%h spc=%h smsr=%h nmsr=%h fwe=%b fst=%h flush=1",
                             ent_num_o, vec_o, save_pc_o, save_msr_o, msr_o, fst_we_o,
                             fst_o, flush_o, e.num, e.vec, e.spc, e.smsr, e.nmsr,
                             e.fwe, e.fst);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        nvec++;
        if (ent_vld_o !== 1'b0 || flush_o !== 1'b0 || fst_we_o !== 1'b0 ||
            vec_o !== 32'h0 || fst_o !== 32'h0) begin
            nbad++;
            $display("FAIL R1: vld=%b flush=%b fwe=%b vec=%h fst=%h expected all 0",
                     ent_vld_o, flush_o, fst_we_o, vec_o, fst_o);
        end
        rst_n = 1'b1;
        // R1: nothing pending after reset
        take_idle("R1");

        // R7 R4: no-translation + store, save current address
        post(16'h0008);
        take(4'd3, 7'b001_0001, 32'h0000_1000, 32'hFFFF_FFFF, 1'b1);
        // R7: no-translation beats protection; breakpoint modifier (R8)
        post(16'h0008);
        take(4'd3, 7'b010_0011, 32'h0000_2000, 32'h0000_4030, 1'b0);
        // R8: direct ignored when protection is primary; external modifier
        post(16'h0008);
        take(4'd3, 7'b100_1110, 32'h1234_5678, 32'h0000_8001, 1'b0);
        // R8: unsupported + direct + store
        post(16'h0008);
        take(4'd3, 7'b001_1100, 32'h8000_0004, 32'hA5A5_A5A5, 1'b1);
        // R7: non-data-fault entry keeps the status word
        post(16'h0080);
        take(4'd7, 7'b111_1111, 32'h0000_0100, 32'h0000_C0F0, 1'b1);
        // R8: direct without unsupported gives nothing
        post(16'h0008);
        take(4'd3, 7'b000_1000, 32'h0000_0040, 32'h0, 1'b0);

        // R2 R6: two sources pending, lowest first, then none
        post(16'h0204);
        take(4'd2, 7'h00, 32'h0000_3000, 32'h1111_1111, 1'b0);
        take(4'd9, 7'h00, 32'h0000_3004, 32'h2222_2222, 1'b1);
        take_idle("R6");

        // R3: boundary numbers; R4: wrap at address zero
        post(16'h8001);
        take(4'd0, 7'h00, 32'h0000_0000, 32'h0000_0010, 1'b1);
        take(4'd15, 7'h00, 32'hFFFF_FFFC, 32'h0000_0020, 1'b0);
        // R6: the data-fault source raised again alongside a higher one
        post(16'h0408);
        take(4'd3, 7'b100_0100, 32'h0000_5000, 32'h0, 1'b1);
        take(4'd10, 7'h00, 32'h0000_6000, 32'h0, 1'b0);
        take_idle("R6");

        repeat (3) @(negedge clk);
        // R2: every expected entry appeared
        nvec++;
        if (sb.size() != 0) begin
            nbad++;
            $display("FAIL R2: %0d entries missing expected 0", sb.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule